// File: doc/BRIEF.md
# DMA Bus Width Conversion Sequencer

This block is the bus-cycle sequencer inside one DMA channel. For each start strobe it moves a single transfer unit, either a byte or a halfword, from a source address to a destination address. Each side sits on a bus that is 8 or 16 bits wide. When the two widths differ, the sequencer splits a halfword into two byte cycles or merges two bytes into one halfword. The byte order of a split or merge follows an endianness select. The data passes through a 16-bit holding register between the read phase and the write phase.

Before it issues any bus cycle, the block checks the request. It refuses a source or destination address inside the reserved page range 0x3FFF000 to 0x3FFFFFF. It also refuses a request that touches the on-chip peripheral window (0xFFFF000 to 0xFFFFFFF) when the transfer size differs from that endpoint's register width. The register width is given by that side's bus width. A refused request produces a one-clock error pulse and no bus activity. An accepted request runs its read and write cycles, each held until acknowledged, and ends with a one-clock done pulse.

Top module: `dma_width_seq`

## Requirements
- R1: While reset is held and after it is released, `bus_req_o`, `done_o`, `err_o`, `busy_o` and `bus_hi_oe_o` are low until a start is accepted.
- R2: A start whose source or destination address lies in 0x3FFF000..0x3FFFFFF (inclusive) gives `err_o` high for exactly one clock, in the cycle after the start. No bus request is issued for it. Addresses 0x3FFEFFF and 0x4000000 are accepted.
- R3: A start whose source or destination lies in 0xFFFF000..0xFFFFFFF is refused as in R2 when the transfer size does not match that side's bus width: a halfword to or from an 8-bit side, or a byte to or from a 16-bit side.
- R4: A halfword between two 16-bit buses takes one read and one write. Both cycles use `bus_lane_en_o`=2'b11. The write drives the source word unchanged with `bus_hi_oe_o`=1.
- R5: A halfword from a 16-bit source to an 8-bit destination takes one 16-bit read, then two byte writes at dst and dst+1.
- R6: A halfword from an 8-bit source to a 16-bit destination takes two byte reads at src and src+1, then one 16-bit write at dst.
- R7: For split or merged halfwords, the byte at the lower address is the low byte when `big_end_i`=0 and the high byte when `big_end_i`=1. The low byte is written first in little-endian mode and the high byte first in big-endian mode.
- R8: Every byte-wide cycle uses lane 0 only: `bus_lane_en_o`=2'b01, `bus_hi_oe_o`=0, write data in bits 7:0 with bits 15:8 zero. Read data bits 15:8 are ignored.
- R9: A bus cycle holds its request, direction, address and data until `bus_ack_i` is sampled high. The next cycle begins only after that acknowledge.
- R10: `done_o` is high for exactly one clock, in the cycle after the final write is acknowledged.
- R11: A start strobe while `busy_o` is high is ignored.
- R12: A halfword between two 8-bit buses takes two byte reads, then two byte writes, ordered as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled when idle |
| src_addr_i | input | ADDR_W | Source byte address |
| dst_addr_i | input | ADDR_W | Destination byte address |
| src_wide_i | input | 1 | Source bus is 16 bits (1) or 8 bits (0) |
| dst_wide_i | input | 1 | Destination bus is 16 bits (1) or 8 bits (0) |
| size_half_i | input | 1 | Halfword (1) or byte (0) transfer |
| big_end_i | input | 1 | Big-endian (1) or little-endian (0) byte order |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | Cycle is a write |
| bus_addr_o | output | ADDR_W | Cycle address |
| bus_wdata_o | output | 16 | Write data |
| bus_lane_en_o | output | 2 | Active byte lanes |
| bus_hi_oe_o | output | 1 | Upper lane driven by this block |
| bus_rdata_i | input | 16 | Read data |
| bus_ack_i | input | 1 | Cycle acknowledge |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Request refused pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
The hardest condition to reach from the ports is a second start that arrives in the middle of a transfer, while a cycle is still waiting for its acknowledge. The bench reaches it by raising a start with a reserved address two clocks after an accepted request. At that point the bus responder is holding back its acknowledge on a rotating delay of zero to two clocks. If that start were accepted, the scoreboard would see an error pulse or an extra cycle. The same rotating delays let every split and merge pattern be seen both with back-to-back acknowledges and with held cycles.

// File: rtl/dws_pkg.sv
// Package: shared types for the DMA width conversion sequencer.
// Assumes a 16-bit data path split into 8-bit lanes.
package dws_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FAULT
    } dws_state_e;

    typedef struct packed {
        logic src_wide;
        logic dst_wide;
        logic half;
        logic big_end;
    } dws_mode_t;
endpackage

// File: rtl/dws_addr_check.sv
// Module: dws_addr_check
// Decides, combinationally, whether a request must be refused.
// Refusal causes: an address on a reserved page range, or a peripheral
// endpoint whose register width differs from the transfer size.
// Assumes the page tag is the address bits above PAGE_W.
module dws_addr_check
    import dws_pkg::*;
#(
    parameter int ADDR_W   = 28,
    parameter int PAGE_W   = 12,
    parameter int BAD_TAG  = 'h3FFF,
    parameter int PERI_TAG = 'hFFFF
) (
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  dws_mode_t         mode_i,
    output logic              fault_o
);
    localparam int TAG_W = ADDR_W - PAGE_W;
    localparam logic [TAG_W-1:0] BAD_T  = TAG_W'(BAD_TAG);
    localparam logic [TAG_W-1:0] PERI_T = TAG_W'(PERI_TAG);

    logic src_bad, dst_bad, src_peri, dst_peri, src_size_bad, dst_size_bad;

    // Classify each endpoint by its page tag.
    always_comb begin
        src_bad  = (src_addr_i[ADDR_W-1:PAGE_W] == BAD_T);
        dst_bad  = (dst_addr_i[ADDR_W-1:PAGE_W] == BAD_T);
        src_peri = (src_addr_i[ADDR_W-1:PAGE_W] == PERI_T);
        dst_peri = (dst_addr_i[ADDR_W-1:PAGE_W] == PERI_T);
    end

    // Peripheral registers must be accessed at their own width.
    always_comb begin
        src_size_bad = src_peri && (mode_i.half != mode_i.src_wide);
        dst_size_bad = dst_peri && (mode_i.half != mode_i.dst_wide);
        fault_o      = src_bad || dst_bad || src_size_bad || dst_size_bad;
    end
endmodule

// File: rtl/dws_plan.sv
// Module: dws_plan
// Derives the cycle shape of each phase from the latched mode: whether a
// phase uses both lanes in one cycle, or takes two byte cycles.
// Assumes bus widths of 8 or 16 bits only.
module dws_plan
    import dws_pkg::*;
(
    input  dws_mode_t mode_i,
    output logic      rd_full_o,
    output logic      rd_split_o,
    output logic      wr_full_o,
    output logic      wr_split_o
);
    // A halfword on a wide side is one cycle; on a narrow side it is two.
    always_comb begin
        rd_full_o  = mode_i.half &&  mode_i.src_wide;
        rd_split_o = mode_i.half && !mode_i.src_wide;
        wr_full_o  = mode_i.half &&  mode_i.dst_wide;
        wr_split_o = mode_i.half && !mode_i.dst_wide;
    end
endmodule

// File: rtl/dws_hold.sv
// Module: dws_hold
// Holding register between read and write phases. A full capture loads
// every lane; a byte capture loads read lane 0 into the selected lane.
// Assumes cap_lane_i indexes lanes 0..LANES-1.
module dws_hold
    import dws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic              cap_full_i,
    input  logic              cap_lane_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] hold_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // Load this lane from its own bus lane or from bus lane 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (cap_en_i) begin
                if (cap_full_i) begin
                    lane_q <= rdata_i[g*LANE_W +: LANE_W];
                end else if (cap_lane_i == 1'(g)) begin
                    lane_q <= rdata_i[LANE_W-1:0];
                end
            end
        end

        assign hold_o[g*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/dws_ctrl.sv
// Module: dws_ctrl
// Phase sequencer: accepts a start when idle, latches the request, walks
// the read cycles then the write cycles, each held until acknowledged,
// and drives the bus fields for the current cycle.
// Assumes the planner and hold register are fed from its latched state.
module dws_ctrl
    import dws_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fault_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  dws_mode_t         mode_i,
    input  logic              rd_full_i,
    input  logic              rd_split_i,
    input  logic              wr_full_i,
    input  logic              wr_split_i,
    input  logic [DATA_W-1:0] hold_i,
    input  logic              bus_ack_i,
    output dws_mode_t         mode_q_o,
    output logic              cap_en_o,
    output logic              cap_full_o,
    output logic              cap_lane_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [LANES-1:0]  bus_lane_en_o,
    output logic              bus_hi_oe_o,
    output logic              done_o,
    output logic              err_o,
    output logic              busy_o
);
    dws_state_e        state_q, state_d;
    logic              idx_q, idx_d;
    dws_mode_t         mode_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic              byte_sel;
    logic [LANE_W-1:0] wr_byte;

    // Next-state and byte-index logic.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = fault_i ? ST_FAULT : ST_READ;
                    idx_d   = 1'b0;
                end
            end
            ST_READ: begin
                if (bus_ack_i) begin
                    if (rd_split_i && !idx_q) begin
                        idx_d = 1'b1;
                    end else begin
                        idx_d   = 1'b0;
                        state_d = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (bus_ack_i) begin
                    if (wr_split_i && !idx_q) begin
                        idx_d = 1'b1;
                    end else begin
                        idx_d   = 1'b0;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Latch the request parameters when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            mode_q <= mode_i;
            src_q  <= src_addr_i;
            dst_q  <= dst_addr_i;
        end
    end

    // Lane of the holding register that the current byte cycle uses.
    always_comb begin
        byte_sel = idx_q ^ mode_q.big_end;
        wr_byte  = hold_i[LANE_W-1:0];
        if (wr_split_i) begin
            wr_byte = byte_sel ? hold_i[2*LANE_W-1:LANE_W] : hold_i[LANE_W-1:0];
        end
    end

    // Capture controls toward the holding register.
    always_comb begin
        cap_en_o   = (state_q == ST_READ) && bus_ack_i;
        cap_full_o = rd_full_i;
        cap_lane_o = rd_split_i ? byte_sel : 1'b0;
    end

    // Bus cycle fields for the current state.
    always_comb begin
        bus_req_o     = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_we_o      = (state_q == ST_WRITE);
        bus_addr_o    = '0;
        bus_wdata_o   = '0;
        bus_lane_en_o = '0;
        bus_hi_oe_o   = 1'b0;
        if (state_q == ST_READ) begin
            bus_addr_o    = src_q + ADDR_W'(idx_q);
            bus_lane_en_o = rd_full_i ? '1 : LANES'(1);
        end else if (state_q == ST_WRITE) begin
            bus_addr_o    = dst_q + ADDR_W'(idx_q);
            bus_lane_en_o = wr_full_i ? '1 : LANES'(1);
            bus_hi_oe_o   = wr_full_i;
            bus_wdata_o   = wr_full_i ? hold_i : {{(DATA_W-LANE_W){1'b0}}, wr_byte};
        end
    end

    // Status decode.
    always_comb begin
        done_o   = (state_q == ST_DONE);
        err_o    = (state_q == ST_FAULT);
        busy_o   = (state_q != ST_IDLE);
        mode_q_o = mode_q;
    end
endmodule

// File: rtl/dma_width_seq.sv
// Module: dma_width_seq
// Top of the DMA width conversion sequencer: one transfer unit per start,
// with split/merge across 8/16-bit buses, endian byte ordering and
// refusal of reserved or mis-sized peripheral requests.
// Assumes a single outstanding bus cycle, completed by bus_ack_i.
module dma_width_seq
    import dws_pkg::*;
#(
    parameter int ADDR_W   = 28,
    parameter int PAGE_W   = 12,
    parameter int BAD_TAG  = 'h3FFF,
    parameter int PERI_TAG = 'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic              src_wide_i,
    input  logic              dst_wide_i,
    input  logic              size_half_i,
    input  logic              big_end_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [15:0]       bus_wdata_o,
    output logic [1:0]        bus_lane_en_o,
    output logic              bus_hi_oe_o,
    input  logic [15:0]       bus_rdata_i,
    input  logic              bus_ack_i,
    output logic              done_o,
    output logic              err_o,
    output logic              busy_o
);
    dws_mode_t         mode_in, mode_q;
    logic              fault;
    logic              rd_full, rd_split, wr_full, wr_split;
    logic              cap_en, cap_full, cap_lane;
    logic [DATA_W-1:0] hold;

    // Pack the request mode.
    always_comb begin
        mode_in.src_wide = src_wide_i;
        mode_in.dst_wide = dst_wide_i;
        mode_in.half     = size_half_i;
        mode_in.big_end  = big_end_i;
    end

    dws_addr_check #(
        .ADDR_W  (ADDR_W),
        .PAGE_W  (PAGE_W),
        .BAD_TAG (BAD_TAG),
        .PERI_TAG(PERI_TAG)
    ) u_check (
        .src_addr_i(src_addr_i),
        .dst_addr_i(dst_addr_i),
        .mode_i    (mode_in),
        .fault_o   (fault)
    );

    dws_plan u_plan (
        .mode_i    (mode_q),
        .rd_full_o (rd_full),
        .rd_split_o(rd_split),
        .wr_full_o (wr_full),
        .wr_split_o(wr_split)
    );

    dws_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en_i  (cap_en),
        .cap_full_i(cap_full),
        .cap_lane_i(cap_lane),
        .rdata_i   (bus_rdata_i),
        .hold_o    (hold)
    );

    dws_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .fault_i      (fault),
        .src_addr_i   (src_addr_i),
        .dst_addr_i   (dst_addr_i),
        .mode_i       (mode_in),
        .rd_full_i    (rd_full),
        .rd_split_i   (rd_split),
        .wr_full_i    (wr_full),
        .wr_split_i   (wr_split),
        .hold_i       (hold),
        .bus_ack_i    (bus_ack_i),
        .mode_q_o     (mode_q),
        .cap_en_o     (cap_en),
        .cap_full_o   (cap_full),
        .cap_lane_o   (cap_lane),
        .bus_req_o    (bus_req_o),
        .bus_we_o     (bus_we_o),
        .bus_addr_o   (bus_addr_o),
        .bus_wdata_o  (bus_wdata_o),
        .bus_lane_en_o(bus_lane_en_o),
        .bus_hi_oe_o  (bus_hi_oe_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .busy_o       (busy_o)
    );
endmodule

// File: rtl/dws_checker.sv
// Module: dws_checker
// Port-level temporal checks for dma_width_seq, attached by bind.
module dws_checker #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [15:0]       bus_wdata_o,
    input logic [1:0]        bus_lane_en_o,
    input logic              bus_hi_oe_o,
    input logic              bus_ack_i,
    input logic              done_o,
    input logic              err_o,
    input logic              busy_o
);
    // R1: an idle block issues no bus cycle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    // R2: a refusal carries no bus cycle and lasts one clock.
    a_r2_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !bus_req_o);
    a_r2_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R4: the upper lane is driven only during a write cycle.
    a_r4_hi_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hi_oe_o |-> (bus_req_o && bus_we_o));

    // R8: a byte-lane cycle never drives the upper lane.
    a_r8_byte_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_lane_en_o == 2'b01) |-> !bus_hi_oe_o);

    // R9: an unacknowledged cycle is held unchanged.
    a_r9_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o)
            && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    // R10: done follows an acknowledged write and lasts one clock.
    a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_req_o && bus_we_o && bus_ack_i));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind dma_width_seq dws_checker #(.ADDR_W(ADDR_W)) u_dws_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_lane_en_o(bus_lane_en_o),
    .bus_hi_oe_o  (bus_hi_oe_o),
    .bus_ack_i    (bus_ack_i),
    .done_o       (done_o),
    .err_o        (err_o),
    .busy_o       (busy_o)
);

// File: tb/dma_width_seq_tb_top.sv
// Scoreboard bench: the driver queues the expected bus cycles and the
// closing pulse; the monitor/responder pops and compares at negedges.
module dma_width_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 28;

    typedef struct {
        int          kind;   // 0 bus cycle, 1 done, 2 error
        logic        we;
        logic [AW-1:0] addr;
        logic [15:0] wdata;
        logic [1:0]  lane;
        logic        hioe;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] src_addr_i = '0;
    logic [AW-1:0] dst_addr_i = '0;
    logic          src_wide_i = 1'b0;
    logic          dst_wide_i = 1'b0;
    logic          size_half_i = 1'b0;
    logic          big_end_i = 1'b0;
    logic          bus_req_o, bus_we_o, bus_hi_oe_o;
    logic [AW-1:0] bus_addr_o;
    logic [15:0]   bus_wdata_o;
    logic [1:0]    bus_lane_en_o;
    logic [15:0]   bus_rdata_i = 16'hDEAD;
    logic          bus_ack_i = 1'b0;
    logic          done_o, err_o, busy_o;

    int     n_checks = 0;
    int     n_errors = 0;
    int     wait_cnt = 0;
    int     delay_sel = 0;
    logic   done_prev = 1'b0;
    logic   err_prev = 1'b0;
    item_t  exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_width_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
        .src_wide_i(src_wide_i), .dst_wide_i(dst_wide_i),
        .size_half_i(size_half_i), .big_end_i(big_end_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_lane_en_o(bus_lane_en_o),
        .bus_hi_oe_o(bus_hi_oe_o), .bus_rdata_i(bus_rdata_i),
        .bus_ack_i(bus_ack_i), .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
    );

    // Memory model word: low byte is the address, high byte a mix of it.
    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_bus(input logic we, input logic [AW-1:0] a, input logic [15:0] d,
                            input logic [1:0] ln, input logic hi, input string req);
        item_t it;
        it.kind = 0; it.we = we; it.addr = a; it.wdata = d; it.lane = ln; it.hioe = hi;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic push_end(input int kind, input string req);
        item_t it;
        it.kind = kind; it.we = 0; it.addr = '0; it.wdata = '0; it.lane = '0;
        it.hioe = 0; it.req = req;
        exp_q.push_back(it);
    endtask

    // Driver: queue the expected cycles from the requirements, then start.
    task automatic run_xfer(input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input logic sw, input logic dw, input logic half,
                            input logic be, input bit refuse, input bit poke,
                            input string req);
        logic [15:0] hw;
        logic [7:0]  lo_first, hi_second;
        if (refuse) begin
            push_end(2, req);
        end else begin
            if (half) begin
                if (sw) begin
                    push_bus(0, s, 16'h0, 2'b11, 0, req);
                    hw = mem_word(s);
                end else begin
                    push_bus(0, s, 16'h0, 2'b01, 0, req);
                    push_bus(0, s + 1, 16'h0, 2'b01, 0, req);
                    hw = be ? {s[7:0], 8'(s + 1)} : {8'(s + 1), s[7:0]};
                end
                if (dw) begin
                    push_bus(1, d, hw, 2'b11, 1, req);
                end else begin
                    lo_first  = be ? hw[15:8] : hw[7:0];
                    hi_second = be ? hw[7:0] : hw[15:8];
                    push_bus(1, d, {8'h00, lo_first}, 2'b01, 0, req);
                    push_bus(1, d + 1, {8'h00, hi_second}, 2'b01, 0, req);
                end
            end else begin
                push_bus(0, s, 16'h0, 2'b01, 0, req);
                push_bus(1, d, {8'h00, s[7:0]}, 2'b01, 0, req);
            end
            push_end(1, req);
        end
        @(negedge clk);
        src_addr_i = s; dst_addr_i = d; src_wide_i = sw; dst_wide_i = dw;
        size_half_i = half; big_end_i = be; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R11: a refused-looking start while busy must leave no trace.
            @(negedge clk);
            check(busy_o === 1'b1, "R11", "busy before poke", 64'(busy_o), 64'h1);
            src_addr_i = 28'h3FFF100; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor and bus responder: compare at negedge, answer with rotating delay.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && done_prev)
                check(0, "R10", "done longer than one clock", 64'h1, 64'h0);
            if (err_o && err_prev)
                check(0, "R2", "err longer than one clock", 64'h1, 64'h0);
            done_prev <= done_o;
            err_prev  <= err_o;
            bus_ack_i   <= 1'b0;
            bus_rdata_i <= 16'hDEAD;
            if (bus_req_o) begin
                if (exp_q.size() == 0 || exp_q[0].kind != 0) begin
                    check(0, "R9", "unexpected bus cycle", 64'(bus_addr_o), 64'h0);
                end else begin
                    check(bus_we_o === exp_q[0].we, exp_q[0].req, "direction",
                          64'(bus_we_o), 64'(exp_q[0].we));
                    check(bus_addr_o === exp_q[0].addr, exp_q[0].req, "address",
                          64'(bus_addr_o), 64'(exp_q[0].addr));
                    check(bus_lane_en_o === exp_q[0].lane, exp_q[0].req, "lanes",
                          64'(bus_lane_en_o), 64'(exp_q[0].lane));
                    check(bus_hi_oe_o === exp_q[0].hioe, exp_q[0].req, "upper enable",
                          64'(bus_hi_oe_o), 64'(exp_q[0].hioe));
                    if (exp_q[0].we)
                        check(bus_wdata_o === exp_q[0].wdata, exp_q[0].req, "write data",
                              64'(bus_wdata_o), 64'(exp_q[0].wdata));
                    if (wait_cnt >= delay_sel) begin
                        bus_ack_i   <= 1'b1;
                        bus_rdata_i <= mem_word(bus_addr_o);
                        wait_cnt    <= 0;
                        delay_sel   <= (delay_sel + 1) % 3;
                        void'(exp_q.pop_front());
                    end else begin
                        wait_cnt <= wait_cnt + 1;
                    end
                end
            end
            if (done_o) begin
                if (exp_q.size() != 0 && exp_q[0].kind == 1) begin
                    check(1, "R10", "done", 64'h1, 64'h1);
                    void'(exp_q.pop_front());
                end else begin
                    check(0, "R10", "unexpected done", 64'h1, 64'h0);
                end
            end
            if (err_o) begin
                if (exp_q.size() != 0 && exp_q[0].kind == 2) begin
                    check(1, exp_q[0].req, "error pulse", 64'h1, 64'h1);
                    void'(exp_q.pop_front());
                end else begin
                    check(0, "R2", "unexpected error", 64'h1, 64'h0);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R9", "watchdog expired", 64'h0, 64'h1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(bus_req_o === 0 && done_o === 0 && err_o === 0 && busy_o === 0
              && bus_hi_oe_o === 0, "R1", "outputs in reset",
              {bus_req_o, done_o, err_o, busy_o, bus_hi_oe_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 0 && bus_req_o === 0, "R1", "idle after reset",
              {busy_o, bus_req_o}, 64'h0);

        run_xfer(28'h0001230, 28'h0004560, 1, 1, 1, 0, 0, 0, "R4");
        run_xfer(28'h0001240, 28'h0004571, 1, 0, 1, 0, 0, 0, "R5");
        run_xfer(28'h0001242, 28'h0004580, 1, 0, 1, 1, 0, 0, "R7");
        run_xfer(28'h0001317, 28'h0004590, 0, 1, 1, 0, 0, 0, "R6");
        run_xfer(28'h0001320, 28'h00045A0, 0, 1, 1, 1, 0, 0, "R7");
        run_xfer(28'h0001333, 28'h00045B5, 0, 0, 1, 1, 0, 0, "R12");
        run_xfer(28'h0001344, 28'h00045C6, 0, 0, 1, 0, 0, 0, "R12");
        run_xfer(28'h0001359, 28'h00045D0, 1, 0, 0, 0, 0, 0, "R8");
        run_xfer(28'h000136B, 28'h00045E1, 0, 1, 0, 1, 0, 0, "R8");
        run_xfer(28'h000137C, 28'h00045F3, 1, 1, 0, 0, 0, 0, "R8");
        run_xfer(28'h3FFF000, 28'h0004600, 1, 1, 1, 0, 1, 0, "R2");
        run_xfer(28'h0001400, 28'h3FFFFFF, 1, 1, 0, 0, 1, 0, "R2");
        run_xfer(28'h3FFEFFF, 28'h4000000, 0, 0, 0, 0, 0, 0, "R2");
        run_xfer(28'h0001410, 28'hFFFF010, 1, 0, 1, 0, 1, 0, "R3");
        run_xfer(28'hFFFF020, 28'h0004620, 1, 1, 0, 0, 1, 0, "R3");
        run_xfer(28'h0001430, 28'hFFFF030, 1, 1, 1, 0, 0, 0, "R3");
        run_xfer(28'h0001440, 28'h0004640, 0, 0, 1, 0, 0, 1, "R11");
        run_xfer(28'h0001451, 28'h0004651, 1, 0, 1, 1, 0, 1, "R11");

        check(exp_q.size() == 0, "R10", "scoreboard drained", 64'(exp_q.size()), 64'h0);
        check(busy_o === 0, "R11", "idle at end", 64'(busy_o), 64'h0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule